// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits between a host write path and the page-write controller of a byte-writable nonvolatile array. It watches every write cycle the host issues and compares each address/data pair against two fixed command sequences. Its main output, `wr_allow_o`, tells the page-write controller whether the write presented in the same cycle may reach the array. Writes that form part of a command sequence never reach the array.

A three-write unlock sequence turns protection on, whatever its previous state, and opens one load window. During that window up to `PAGE_BYTES` array writes pass. The window closes after the last of those bytes, or when the host leaves `LOAD_WIN` clock cycles without a write. A six-write disable sequence clears protection `PROG_CYC` cycles after its last write. During that delay the block blocks and ignores every write. The protection flag models a nonvolatile bit. A `pwr_cyc` pulse models a power cycle: it clears the matcher, the load window and any pending disable, and keeps the flag. Only `rst_n`, which models a device fresh from the factory, clears the flag.

Top module: `wprot_cmd_guard`

## Requirements
- R1: After `rst_n` the block is unprotected and `seq_state_o` is 0. While unprotected, every write that is not a command write gets `wr_allow_o`=1 in the cycle it is presented.
- R2: The writes AA@5555, 55@2AAA, A0@5555 (hex data @ hex address), presented in that order, set `protected_o` to 1 whatever its earlier value, open a load window and return `seq_state_o` to 0. Each of these writes has `wr_allow_o`=0.
- R3: While protected and no load window is open, every write has `wr_allow_o`=0.
- R4: An open load window allows `PAGE_BYTES` array writes and then closes. It also closes once `LOAD_WIN` consecutive cycles pass without a write. A write after `LOAD_WIN`-1 idle cycles still lands inside the window.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 drop `protected_o` exactly `PROG_CYC` clock edges after the edge that samples the last of them. Until then, every write has `wr_allow_o`=0 and leaves `seq_state_o` at 0.
- R6: If `LOAD_WIN` consecutive idle cycles pass between two steps, `seq_state_o` returns to 0. A step that follows `LOAD_WIN`-1 idle cycles still advances the sequence.
- R7: A write that is not the expected next step sets `seq_state_o` to 0. If that write is AA@5555, `seq_state_o` becomes 1 instead. A non-matching write other than AA@5555 is an array write and is allowed or blocked under R1/R3/R4.
- R8: In a cycle with `pwr_cyc`=1, no write is allowed. On that edge the matcher and the load window are cleared and any pending disable is cancelled, while `protected_o` keeps its value.
- R9: `seq_state_o` is the number of sequence steps matched so far, from 0 to 5. It returns to 0 when a sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also clears the persistent flag |
| pwr_cyc | input | 1 | Modelled power cycle; keeps the protection flag |
| wr_stb | input | 1 | A host write cycle is presented |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| wr_allow_o | output | 1 | The presented write may go to the array |
| protected_o | output | 1 | Persistent protection flag |
| seq_state_o | output | 3 | Command steps matched so far |

## Verification
A wrong step counter shows at `seq_state_o` right after the edge that samples the write, and a missing or extra unlock shows at `wr_allow_o` on the very next array write. Load-window and idle-timeout errors are exposed by writes placed exactly one cycle inside and one cycle outside each limit. A disable delay that is off by one edge shows on `protected_o`, which is sampled at the edge before and the edge after the expected fall. Power-cycle handling is checked both with a load window open and with a disable pending.

// File: rtl/wprot_cmd_guard.sv
module wprot_cmd_guard #(
  parameter int LOAD_WIN   = 25000,
  parameter int PAGE_BYTES = 128,
  parameter int PROG_CYC   = 1250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_cyc,
  input  logic        wr_stb,
  input  logic [14:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        wr_allow_o,
  output logic        protected_o,
  output logic [2:0]  seq_state_o
);
  localparam int GW = $clog2(LOAD_WIN + 1);
  localparam int LW = $clog2(PAGE_BYTES + 1);
  localparam int DW = $clog2(PROG_CYC + 1);
  localparam logic [14:0] A_HI = 15'h5555;
  localparam logic [14:0] A_LO = 15'h2AAA;

  logic [2:0]    st;
  logic          prot, win, busy;
  logic [GW-1:0] gap;
  logic [LW-1:0] ld;
  logic [DW-1:0] dly;
  logic [14:0]   ex_a;
  logic [7:0]    ex_d;

  always_comb begin
    ex_a = A_HI;
    ex_d = 8'hAA;
    case (st)
      3'd1:    begin ex_a = A_LO; ex_d = 8'h55; end
      3'd2:    ex_d = 8'h80;
      3'd4:    begin ex_a = A_LO; ex_d = 8'h55; end
      3'd5:    ex_d = 8'h20;
      default: ;
    endcase
  end

  assign busy = dly != '0;

  logic live, is_aa, step_ok, unlock, is_cmd, done_dis, tmo, last_ld;
  assign live     = wr_stb & ~pwr_cyc & ~busy;
  assign is_aa    = (wr_addr == A_HI) && (wr_data == 8'hAA);
  assign step_ok  = (wr_addr == ex_a) && (wr_data == ex_d);
  assign unlock   = live && (st == 3'd2) && (wr_addr == A_HI) && (wr_data == 8'hA0);
  assign is_cmd   = step_ok | unlock | is_aa;
  assign done_dis = live && (st == 3'd5) && step_ok;
  assign tmo      = ~wr_stb && (gap == GW'(LOAD_WIN - 1));

  assign wr_allow_o  = live & ~is_cmd & (~prot | win);
  assign last_ld     = ld == LW'(PAGE_BYTES - 1);
  assign protected_o = prot;
  assign seq_state_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      prot <= 1'b0;
      win  <= 1'b0;
      gap  <= '0;
      ld   <= '0;
      dly  <= '0;
    end else begin
      if (wr_stb) gap <= '0;
      else if (gap != GW'(LOAD_WIN - 1)) gap <= gap + 1'b1;

      if (pwr_cyc) begin
        st  <= '0;
        win <= 1'b0;
        ld  <= '0;
        dly <= '0;
      end else begin
        if (busy) begin
          dly <= dly - 1'b1;
          if (dly == DW'(1)) prot <= 1'b0;
        end
        if (tmo) begin
          st  <= '0;
          win <= 1'b0;
        end else if (live) begin
          if (unlock) begin
            prot <= 1'b1;
            win  <= 1'b1;
            ld   <= '0;
            st   <= '0;
          end else if (done_dis) begin
            st  <= '0;
            win <= 1'b0;
            dly <= DW'(PROG_CYC);
          end else if (step_ok) st <= st + 1'b1;
          else if (is_aa)       st <= 3'd1;
          else                  st <= '0;
          if (wr_allow_o && win) begin
            ld <= ld + 1'b1;
            if (last_ld) win <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wprot_cmd_guard_chk.sv
module wprot_cmd_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_cyc,
  input logic        wr_stb,
  input logic [7:0]  wr_data,
  input logic        wr_allow_o,
  input logic        protected_o,
  input logic [2:0]  seq_state_o,
  input logic        win,
  input logic        busy
);
  p_allow_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow_o |-> (wr_stb && (!protected_o || win)));

  p_state_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state_o <= 3'd5);

  p_rise_on_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protected_o) |-> $past(wr_stb && wr_data == 8'hA0 && seq_state_o == 3'd2));

  p_fall_after_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protected_o) |-> $past(busy));

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_allow_o);

  p_pwr_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cyc |=> $stable(protected_o));

  p_pwr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cyc |=> (seq_state_o == 3'd0 && !win && !busy));
endmodule

bind wprot_cmd_guard wprot_cmd_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_cyc(pwr_cyc), .wr_stb(wr_stb),
  .wr_data(wr_data), .wr_allow_o(wr_allow_o), .protected_o(protected_o),
  .seq_state_o(seq_state_o), .win(win), .busy(busy)
);

// File: tb/wprot_cmd_guard_tb.sv
module wprot_cmd_guard_tb;
  localparam int LW = 8, PB = 4, PC = 20;
  logic clk = 1'b0, rst_n = 1'b0, pwr_cyc = 1'b0, wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_allow_o, protected_o;
  logic [2:0] seq_state_o;
  int n_tests = 0, n_fail = 0;
  logic al;

  always #2 clk = ~clk;

  wprot_cmd_guard #(.LOAD_WIN(LW), .PAGE_BYTES(PB), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_cyc(pwr_cyc), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_allow_o(wr_allow_o),
    .protected_o(protected_o), .seq_state_o(seq_state_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, output logic allow);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1 allow = wr_allow_o;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pwr_pulse();
    pwr_cyc = 1'b1;
    @(negedge clk);
    pwr_cyc = 1'b0;
  endtask

  task automatic unlock_seq(input string tag);
    wr(15'h5555, 8'hAA, al); chk({tag, " step1 allow"}, al, 0); chk({tag, " st1"}, seq_state_o, 1);
    wr(15'h2AAA, 8'h55, al); chk({tag, " step2 allow"}, al, 0); chk({tag, " st2"}, seq_state_o, 2);
    wr(15'h5555, 8'hA0, al); chk({tag, " step3 allow"}, al, 0); chk({tag, " st0"}, seq_state_o, 0);
  endtask

  task automatic disable_seq();
    logic [14:0] a [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
    logic [7:0]  d [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    for (int i = 0; i < 6; i++) begin
      wr(a[i], d[i], al);
      chk("R5 disable step blocked", al, 0);
      chk("R9 disable step state", seq_state_o, (i == 5) ? 0 : i + 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset protected", protected_o, 0);
    chk("R9 reset state", seq_state_o, 0);

    for (int i = 1; i < 33; i++) begin
      wr(15'(i * 16'h0101), 8'(i * 37), al);
      chk("R1 unprotected write allowed", al, 1);
    end

    wr(15'h5555, 8'hAA, al); chk("R7 AA@5555 is command", al, 0); chk("R9 st after AA", seq_state_o, 1);
    wr(15'h2AAA, 8'h55, al); chk("R9 st after 55", seq_state_o, 2);
    wr(15'h0100, 8'h12, al); chk("R7 mismatch is array write", al, 1); chk("R7 mismatch idle", seq_state_o, 0);

    wr(15'h5555, 8'hAA, al);
    wr(15'h2AAA, 8'h55, al);
    wr(15'h5555, 8'hAA, al); chk("R7 AA restart step1", seq_state_o, 1);
    wr(15'h2AAA, 8'h55, al);
    wr(15'h5555, 8'hA0, al); chk("R2 unlock state", seq_state_o, 0);
    chk("R2 unlock sets protection", protected_o, 1);

    for (int i = 0; i <= PB; i++) begin
      wr(15'(16'h0200 + i), 8'(i), al);
      chk("R4 window byte", al, (i < PB) ? 1 : 0);
    end

    for (int i = 0; i < 16; i++) begin
      wr(15'(i * 16'h0333), 8'(i), al);
      chk("R3 protected write blocked", al, 0);
    end

    unlock_seq("R2 relock");
    chk("R2 stays protected", protected_o, 1);
    idle(LW - 1);
    wr(15'h0300, 8'h01, al); chk("R4 write at edge of window", al, 1);
    unlock_seq("R2 relock2");
    idle(LW);
    wr(15'h0300, 8'h02, al); chk("R4 window timed out", al, 0);

    wr(15'h5555, 8'hAA, al); idle(LW);
    wr(15'h2AAA, 8'h55, al); chk("R6 gap too long", seq_state_o, 0);
    wr(15'h5555, 8'hAA, al); idle(LW - 1);
    wr(15'h2AAA, 8'h55, al); chk("R6 gap just inside", seq_state_o, 2);
    wr(15'h0000, 8'h00, al); chk("R7 mismatch to idle", seq_state_o, 0);

    unlock_seq("R8 pre");
    pwr_pulse();
    chk("R8 flag kept", protected_o, 1);
    wr(15'h0400, 8'h55, al); chk("R8 window closed by power cycle", al, 0);
    wr(15'h5555, 8'hAA, al);
    pwr_cyc = 1'b1; wr_stb = 1'b1; wr_addr = 15'h0401; wr_data = 8'h00;
    #1 chk("R8 write blocked during power cycle", wr_allow_o, 0);
    @(negedge clk); pwr_cyc = 1'b0; wr_stb = 1'b0;
    chk("R8 matcher cleared", seq_state_o, 0);

    disable_seq();
    wr(15'h0500, 8'h11, al); chk("R5 busy blocks write", al, 0);
    wr(15'h5555, 8'hAA, al); chk("R5 busy ignores step", seq_state_o, 0);
    idle(PC - 3);
    chk("R5 still protected before delay", protected_o, 1);
    idle(1);
    chk("R5 unprotected after delay", protected_o, 0);
    wr(15'h0501, 8'h22, al); chk("R5 write allowed after disable", al, 1);

    unlock_seq("R2 from unprotected");
    chk("R2 protection set again", protected_o, 1);
    disable_seq();
    idle(3);
    pwr_pulse();
    idle(PC + 10);
    chk("R8 power cycle cancels disable", protected_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule